// File: doc/BRIEF.md
# Folded Single-Port Memory Array with Predecoded Rows

This block is a synchronous single-port memory of 2^ADDR_W words, each DATA_W bits wide. Its storage is folded: every physical row holds 2^COL_SEL_W words side by side. With the default parameters this gives 2048 words of 16 bits stored as 256 rows of 128 columns. The low COL_SEL_W address bits choose the word inside a row. The remaining upper bits choose the row.

The row address is split into 2-bit fields. Each field drives a predecoder with a 1-of-4 output, and every word line is the AND of one line taken from each predecoder group. Within the selected row, one multiplexer per data bit picks the addressed word for a read. A write mask built from the same column select confines a write to that word. Bit j of the word at column select c lives in row column j*2^COL_SEL_W + c.

Each clock cycle performs at most one operation. Read data is registered. Write wins when both requests are raised in the same cycle.

Top module: `folded_sram`

## Requirements
- R1: After the asynchronous active-low reset, rdata_o is all zeros.
- R2: A cycle with re_i=1 and we_i=0 at address A makes rdata_o show the word last written to A, starting at the first rising edge after that cycle's inputs are presented (one cycle of latency).
- R3: A write stores wdata_i only into the word selected by addr_i[COL_SEL_W-1:0] within its row; the other words sharing that row keep their contents.
- R4: Addresses that differ only in the row field (addr_i[ADDR_W-1:COL_SEL_W]) reach separate storage; every row-field value, including all zeros and all ones, selects exactly one distinct row.
- R5: When we_i and re_i are both 1, only the write takes place and rdata_o keeps its previous value; a later read returns the newly written word.
- R6: In a cycle with re_i=0, rdata_o keeps its previous value whether or not a write happens.
- R7: For any row address exactly one predecoded line per group and exactly one word line are active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address: row field in the upper bits, column select in the low COL_SEL_W bits |
| we_i | input | 1 | Write request |
| re_i | input | 1 | Read request |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |

## Verification
The bench fills every word with a distinct value. It then rewrites a single word in the middle of a row and reads back all eight of that row's neighbours. A design with a wrong write mask or a wrong bit-to-column interleave would corrupt those neighbours. It also writes to addresses that differ in one row bit at a time, including rows 0 and 255. A predecoder whose group wiring is swapped, or an AND term that is stuck, would alias those rows, so one read would return another row's data. Simultaneous read and write requests, and idle cycles, check that rdata_o holds its value. A design that lets the read win, or that loads the output register on every cycle, would change rdata_o where it must not.

// File: rtl/fold_mem_pkg.sv
package fold_mem_pkg;
  localparam int unsigned PREDEC_BITS  = 2;
  localparam int unsigned PREDEC_LINES = 1 << PREDEC_BITS;

  // Physical column holding bit bit_idx of the word at column select col_sel
  function automatic int unsigned phys_col(int unsigned bit_idx, int unsigned col_sel,
                                           int unsigned fold);
    return bit_idx * fold + col_sel;
  endfunction
endpackage

// File: rtl/fold_predec.sv
module fold_predec
  import fold_mem_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [PREDEC_BITS-1:0]  sel_i,
  output logic [PREDEC_LINES-1:0] line_o
);
  always_comb begin
    line_o = '0;
    line_o[sel_i] = 1'b1;
  end

  assert_predec_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(line_o) == 1)
    else $error("predecoder output not one-hot");
endmodule

// File: rtl/fold_row_dec.sv
module fold_row_dec
  import fold_mem_pkg::*;
#(
  parameter int unsigned ROW_W = 8,
  localparam int unsigned ROWS    = 1 << ROW_W,
  localparam int unsigned NUM_PRE = ROW_W / PREDEC_BITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ROW_W-1:0] row_i,
  output logic [ROWS-1:0]  wl_o
);
  logic [NUM_PRE-1:0][PREDEC_LINES-1:0] pre_lines;

  for (genvar g = 0; g < NUM_PRE; g++) begin : g_pre
    fold_predec u_predec (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (row_i[g*PREDEC_BITS +: PREDEC_BITS]),
      .line_o (pre_lines[g])
    );
  end

  // One AND per row across one line from every predecoder group
  always_comb begin
    for (int r = 0; r < int'(ROWS); r++) begin
      wl_o[r] = 1'b1;
      for (int g = 0; g < int'(NUM_PRE); g++) begin
        wl_o[r] = wl_o[r] & pre_lines[g][(r >> (g*PREDEC_BITS)) % PREDEC_LINES];
      end
    end
  end

  assert_wordline_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wl_o) == 1)
    else $error("word lines not one-hot");

  if (ROW_W % PREDEC_BITS != 0) begin : g_bad_row_w
    initial $error("ROW_W must be a multiple of the predecoder width");
  end
endmodule

// File: rtl/fold_col_mux.sv
module fold_col_mux
  import fold_mem_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned COL_SEL_W = 3,
  localparam int unsigned FOLD = 1 << COL_SEL_W,
  localparam int unsigned COLS = DATA_W * FOLD
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [COL_SEL_W-1:0] csel_i,
  input  logic [COLS-1:0]      line_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rword_o,
  output logic [COLS-1:0]      wmask_o,
  output logic [COLS-1:0]      wline_o
);
  for (genvar j = 0; j < DATA_W; j++) begin : g_bit
    logic [FOLD-1:0] grp;
    assign grp        = line_i[j*FOLD +: FOLD];
    assign rword_o[j] = grp[csel_i];

    for (genvar c = 0; c < FOLD; c++) begin : g_col
      localparam int unsigned PC = phys_col(j, c, FOLD);
      assign wmask_o[PC] = (csel_i == COL_SEL_W'(c));
      assign wline_o[PC] = wdata_i[j];
    end
  end

  assert_wmask_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> $countones(wmask_o) == DATA_W)
    else $error("write mask does not cover exactly one word");
endmodule

// File: rtl/folded_sram.sv
module folded_sram
  import fold_mem_pkg::*;
#(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned COL_SEL_W = 3,
  localparam int unsigned ROW_W = ADDR_W - COL_SEL_W,
  localparam int unsigned ROWS  = 1 << ROW_W,
  localparam int unsigned FOLD  = 1 << COL_SEL_W,
  localparam int unsigned COLS  = DATA_W * FOLD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [COLS-1:0]      mem [ROWS];
  logic [ROWS-1:0]      wl;
  logic [COLS-1:0]      row_line;
  logic [COLS-1:0]      wmask;
  logic [COLS-1:0]      wline;
  logic [DATA_W-1:0]    rd_word;
  logic [DATA_W-1:0]    rdata_q;
  logic [ROW_W-1:0]     row_addr;
  logic [COL_SEL_W-1:0] col_sel;

  assign row_addr = addr_i[ADDR_W-1:COL_SEL_W];
  assign col_sel  = addr_i[COL_SEL_W-1:0];

  fold_row_dec #(.ROW_W(ROW_W)) u_row_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .row_i  (row_addr),
    .wl_o   (wl)
  );

  // Wired-OR of the selected row onto the shared line
  always_comb begin
    row_line = '0;
    for (int r = 0; r < int'(ROWS); r++) begin
      if (wl[r]) row_line = row_line | mem[r];
    end
  end

  fold_col_mux #(.DATA_W(DATA_W), .COL_SEL_W(COL_SEL_W)) u_col_mux (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .csel_i  (col_sel),
    .line_i  (row_line),
    .wdata_i (wdata_i),
    .rword_o (rd_word),
    .wmask_o (wmask),
    .wline_o (wline)
  );

  always_ff @(posedge clk_i) begin
    for (int r = 0; r < int'(ROWS); r++) begin
      if (we_i && wl[r]) mem[r] <= (mem[r] & ~wmask) | (wline & wmask);
    end
  end

  // Write has priority: a read is taken only when no write is requested
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (re_i && !we_i)   rdata_q <= rd_word;
  end

  assign rdata_o = rdata_q;

  assert_read_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !we_i) |=> rdata_o == $past(rd_word))
    else $error("read data not delivered one cycle later");

  assert_write_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> $stable(rdata_o))
    else $error("read data changed during a write");

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o))
    else $error("read data changed without a read");
endmodule

// File: tb/folded_sram_bench.sv
`timescale 1ns/1ps
module folded_sram_bench;
  localparam int AW = 11;
  localparam int DW = 16;
  localparam int CW = 3;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic          re = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  logic [DW-1:0] model [WORDS];
  logic [DW-1:0] exp_q = '0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  folded_sram u_folded_sram (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .re_i(re), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [DW-1:0] pat(int a);
    return DW'((a * 40503) ^ 32'h5A5A);
  endfunction

  function automatic logic [AW-1:0] mk_addr(int row, int col);
    return AW'((row << CW) | col);
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rdata=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive on negedge, capture at posedge, sample at next negedge
  task automatic op(logic w, logic r, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    addr = a; we = w; re = r; wdata = d;
    @(posedge clk);
    if (w) model[a] = d;
    else if (r) exp_q = model[a];
    @(negedge clk);
    we = 1'b0; re = 1'b0;
    check(tag, rdata, exp_q);
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    op(1'b0, 1'b1, a, '0, tag);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    op(1'b1, 1'b0, a, d, "R6 write-only hold");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: rdata=%h expected=finish", rdata);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250414));
    repeat (3) @(negedge clk);
    check("R1 reset value", rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", rdata, '0);

    for (int a = 0; a < WORDS; a++) wr(AW'(a), pat(a));

    // R3: rewrite the middle word of row 5 and read back every word in that row
    wr(mk_addr(5, 3), 16'hC3A5);
    for (int c = 0; c < (1 << CW); c++) rd(mk_addr(5, c), "R3 neighbour intact");

    // R4: flip each row bit in turn, including rows 0 and 255
    for (int b = 0; b < AW - CW; b++) begin
      wr(mk_addr(0, 6), 16'h1111 * DW'(b + 1));
      wr(mk_addr(1 << b, 6), ~(16'h1111 * DW'(b + 1)));
      rd(mk_addr(0, 6), "R4 row 0 distinct");
      rd(mk_addr(1 << b, 6), "R4 single row bit");
    end
    wr(mk_addr(255, 7), 16'hFFFE);
    rd(mk_addr(255, 7), "R4 top row");
    rd(mk_addr(0, 0), "R4 bottom row");

    // R5: both requests at once
    rd(mk_addr(9, 2), "R2 prime");
    op(1'b1, 1'b1, mk_addr(9, 2), 16'hBEEF, "R5 write wins, output holds");
    rd(mk_addr(9, 2), "R5 new word visible");

    // R6: idle cycles
    op(1'b0, 1'b0, mk_addr(100, 1), '0, "R6 idle hold");
    op(1'b0, 1'b0, mk_addr(3, 4), '0, "R6 idle hold");

    // Mixed random traffic (R2, R5, R6)
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] ra;
      logic w, r;
      ra = AW'($urandom);
      w  = ($urandom % 3) == 0;
      r  = ($urandom % 4) != 0;
      op(w, r, ra, DW'($urandom),
         (w && r) ? "R5 random" : (r ? "R2 random read" : "R6 random hold"));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule